// File: doc/BRIEF.md
# Upper-bank register window rotator

This block renames architectural register numbers on the way into decode for a 64-entry register file. The upper half of the file forms a circular window. The lower half is a fixed bank that is never renamed. A single offset register sets how far the window is turned. Software moves the window with a rotate request that carries an even step. Each cycle the block translates two source indices and one destination index into physical indices.

The offset moves in units of two registers, so an even/odd pair always lands on an adjacent even/odd physical pair. Because the low offset bit is always zero, only the upper four bits are stored, and they advance with a wrapping four-bit add. Translation is combinational and always uses the offset as it stood at the start of the cycle. A rotate issued in a cycle first affects translation in the following cycle. An odd step is reported on an error output, and its low bit is dropped.

Top module: `win_rot_top`

## Requirements
- R1: An index in 0..31 leaves the block unchanged on its physical output, whatever the offset.
- R2: An index i in 32..63 maps to 32 + ((i - 32 + offset) mod 32), so the result always stays in 32..63.
- R3: A rotate request with step n sets offset to (offset + n) mod 32, wrapping with no saturation.
- R4: `rot_odd_err_o` is high exactly when `rot_valid_i` is high and bit 0 of `rot_imm_i` is 1. It is low whenever `rot_valid_i` is low.
- R5: An odd step updates the offset as if its bit 0 were 0, so the offset stays even.
- R6: In the cycle a rotate is requested, translation uses the old offset. The new offset applies from the next cycle.
- R7: While `rst_ni` is low, and after reset until the first rotate, the offset is 0 and every index maps to itself.
- R8: The two source ports and the destination port all use the same offset. Equal indices on any two ports give equal physical outputs.
- R9: Bit 0 of every physical index equals bit 0 of its input index, so indices 2k and 2k+1 map to an adjacent even/odd pair.
- R10: While `rot_valid_i` is low, the offset holds, whatever value sits on `rot_imm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rot_valid_i | input | 1 | Rotate request strobe |
| rot_imm_i | input | 5 | Rotate step, expected even, 0..30 |
| rot_odd_err_o | output | 1 | Odd step seen on a valid request |
| src0_idx_i | input | 6 | Architectural index, source 0 |
| src1_idx_i | input | 6 | Architectural index, source 1 |
| dst_idx_i | input | 6 | Architectural index, destination |
| src0_phys_o | output | 6 | Physical index, source 0 |
| src1_phys_o | output | 6 | Physical index, source 1 |
| dst_phys_o | output | 6 | Physical index, destination |

## Verification
The offset can only be seen through translated indices. The case hardest to reach is wrap-around, where an accumulated offset pushes an upper index past 63 back to 32. A second hard case is an odd step, whose stray low bit would break pair alignment only several rotations later. The stimulus steps through every step value from 0 to 31 in turn, so the offset wraps several times and every odd step is mixed in. After each step it sweeps all 64 indices on all three ports. A separate check samples the outputs in the same cycle as each rotate, to catch a new offset leaking in a cycle early.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned RF_IDX_W    = 6;
  localparam int unsigned RF_STEP_LOG = 1;  // rotation granularity = 2**RF_STEP_LOG

  typedef enum logic {
    BANK_FIXED = 1'b0,
    BANK_ROT   = 1'b1
  } bank_e;
endpackage

// File: rtl/rot_offset_reg.sv
module rot_offset_reg #(
  parameter int unsigned WIN_W    = 5,
  parameter int unsigned STEP_LOG = 1,
  localparam int unsigned SH_W    = WIN_W - STEP_LOG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [WIN_W-1:0] imm_i,
  output logic [WIN_W-1:0] off_o,
  output logic             odd_err_o
);
  logic [SH_W-1:0] step_q;
  logic [SH_W-1:0] step_d;

  // Only the aligned part of the step is added; sub-step bits are dropped.
  always_comb begin
    step_d = step_q;
    if (upd_i) step_d = step_q + imm_i[WIN_W-1:STEP_LOG];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign off_o     = {step_q, {STEP_LOG{1'b0}}};
  assign odd_err_o = upd_i & (|imm_i[STEP_LOG-1:0]);
endmodule

// File: rtl/rot_remap.sv
module rot_remap
  import rot_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned WIN_W = IDX_W - 1
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIN_W-1:0] off_i,
  output logic [IDX_W-1:0] phys_o
);
  bank_e           bank;
  logic [WIN_W-1:0] slot;

  assign bank = bank_e'(idx_i[IDX_W-1]);
  assign slot = idx_i[WIN_W-1:0] + off_i;  // wraps inside the window

  always_comb begin
    unique case (bank)
      BANK_ROT:   phys_o = {1'b1, slot};
      default:    phys_o = idx_i;
    endcase
  end
endmodule

// File: rtl/win_rot_top.sv
module win_rot_top
  import rot_pkg::*;
#(
  parameter int unsigned IDX_W    = RF_IDX_W,
  parameter int unsigned STEP_LOG = RF_STEP_LOG,
  localparam int unsigned WIN_W   = IDX_W - 1,
  localparam int unsigned N_PORTS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rot_valid_i,
  input  logic [WIN_W-1:0] rot_imm_i,
  output logic             rot_odd_err_o,
  input  logic [IDX_W-1:0] src0_idx_i,
  input  logic [IDX_W-1:0] src1_idx_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output logic [IDX_W-1:0] src0_phys_o,
  output logic [IDX_W-1:0] src1_phys_o,
  output logic [IDX_W-1:0] dst_phys_o
);
  logic [WIN_W-1:0] off;
  logic [IDX_W-1:0] idx_a  [N_PORTS];
  logic [IDX_W-1:0] phys_a [N_PORTS];

  rot_offset_reg #(
    .WIN_W    (WIN_W),
    .STEP_LOG (STEP_LOG)
  ) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (rot_valid_i),
    .imm_i     (rot_imm_i),
    .off_o     (off),
    .odd_err_o (rot_odd_err_o)
  );

  assign idx_a[0] = src0_idx_i;
  assign idx_a[1] = src1_idx_i;
  assign idx_a[2] = dst_idx_i;

  // Remap uses the registered offset: a same-cycle rotate is not yet visible.
  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    rot_remap #(.IDX_W(IDX_W)) u_map (
      .idx_i  (idx_a[g]),
      .off_i  (off),
      .phys_o (phys_a[g])
    );
  end

  assign src0_phys_o = phys_a[0];
  assign src1_phys_o = phys_a[1];
  assign dst_phys_o  = phys_a[2];
endmodule

// File: rtl/win_rot_chk.sv
module win_rot_chk #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned WIN_W = IDX_W - 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rot_valid_i,
  input logic [WIN_W-1:0] rot_imm_i,
  input logic             rot_odd_err_o,
  input logic [IDX_W-1:0] src0_idx_i,
  input logic [IDX_W-1:0] src1_idx_i,
  input logic [IDX_W-1:0] dst_idx_i,
  input logic [IDX_W-1:0] src0_phys_o,
  input logic [IDX_W-1:0] src1_phys_o,
  input logic [IDX_W-1:0] dst_phys_o
);
  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src0_idx_i[IDX_W-1] |-> src0_phys_o == src0_idx_i); // R1

  AST_UPPER_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_idx_i[IDX_W-1] |-> dst_phys_o[IDX_W-1]); // R2

  AST_NO_ERR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rot_valid_i |-> !rot_odd_err_o); // R4

  AST_NO_ERR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_valid_i && !rot_imm_i[0]) |-> !rot_odd_err_o); // R4

  AST_ZERO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rot_valid_i && rot_imm_i[WIN_W-1:1] == '0) && $stable(src0_idx_i))
      |-> $stable(src0_phys_o)); // R5

  AST_SHARED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src0_idx_i == dst_idx_i) |-> (src0_phys_o == dst_phys_o)); // R8

  AST_PAIR_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src1_phys_o[0] == src1_idx_i[0]); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rot_valid_i) && $stable(src1_idx_i)) |-> $stable(src1_phys_o)); // R10
endmodule

bind win_rot_top win_rot_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rot_valid_i   (rot_valid_i),
  .rot_imm_i     (rot_imm_i),
  .rot_odd_err_o (rot_odd_err_o),
  .src0_idx_i    (src0_idx_i),
  .src1_idx_i    (src1_idx_i),
  .dst_idx_i     (dst_idx_i),
  .src0_phys_o   (src0_phys_o),
  .src1_phys_o   (src1_phys_o),
  .dst_phys_o    (dst_phys_o)
);

// File: tb/win_rot_top_tb_top.sv
`timescale 1ns/1ps
module win_rot_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rot_valid_i = 1'b0;
  logic [4:0] rot_imm_i = '0;
  logic       rot_odd_err_o;
  logic [5:0] src0_idx_i = '0, src1_idx_i = '0, dst_idx_i = '0;
  logic [5:0] src0_phys_o, src1_phys_o, dst_phys_o;

  int checks = 0;
  int errs   = 0;
  int exp_off = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  win_rot_top dut_i (
    .clk_i, .rst_ni, .rot_valid_i, .rot_imm_i, .rot_odd_err_o,
    .src0_idx_i, .src1_idx_i, .dst_idx_i,
    .src0_phys_o, .src1_phys_o, .dst_phys_o
  );

  function automatic int model(int i, int off);
    if (i < 32) return i;
    return 32 + ((i - 32 + off) % 32);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (off=%0d)", req, act, exp, exp_off);
    end
  endtask

  // Full sweep of all 64 indices on all three ports against the model.
  task automatic sweep();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk_i);
      src0_idx_i = 6'(i);
      src1_idx_i = 6'(i ^ 1);
      dst_idx_i  = 6'(63 - i);
      #1;
      chk(i < 32 ? "R1" : "R2", int'(src0_phys_o), model(i, exp_off));
      chk("R8", int'(src1_phys_o), model(i ^ 1, exp_off));
      chk("R8", int'(dst_phys_o), model(63 - i, exp_off));
      chk("R9", int'(src0_phys_o ^ src1_phys_o), 1);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    // R7: identity while in reset, even with a request pending
    rot_valid_i = 1'b1; rot_imm_i = 5'd6;
    repeat (2) @(negedge clk_i);
    src0_idx_i = 6'd33; #1;
    chk("R7", int'(src0_phys_o), 33);
    rot_valid_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    sweep();  // R7 identity after reset

    // R3/R5/R6/R4: step through every immediate, wrapping several times
    for (int n = 0; n < 32; n++) begin
      @(negedge clk_i);
      rot_valid_i = 1'b1; rot_imm_i = 5'(n);
      src0_idx_i = 6'd40; dst_idx_i = 6'd63;
      #1;
      chk("R6", int'(src0_phys_o), model(40, exp_off));
      chk("R6", int'(dst_phys_o), model(63, exp_off));
      chk("R4", int'(rot_odd_err_o), n & 1);
      @(negedge clk_i);
      rot_valid_i = 1'b0;
      exp_off = (exp_off + (n & ~1)) % 32;
      src0_idx_i = 6'd32; #1;
      chk((n & 1) ? "R5" : "R3", int'(src0_phys_o), 32 + exp_off);
      chk("R4", int'(rot_odd_err_o), 0);
      if (n % 4 == 3) sweep();
    end
    sweep();

    // R10: garbage immediate with strobe low leaves offset alone
    @(negedge clk_i);
    rot_imm_i = 5'd14;
    repeat (5) @(negedge clk_i);
    src0_idx_i = 6'd50; #1;
    chk("R10", int'(src0_phys_o), model(50, exp_off));
    chk("R4", int'(rot_odd_err_o), 0);

    // R3: wrap near the top of the window
    @(negedge clk_i);
    rot_valid_i = 1'b1; rot_imm_i = 5'd30;
    @(negedge clk_i);
    rot_valid_i = 1'b0;
    exp_off = (exp_off + 30) % 32;
    src0_idx_i = 6'd63; #1;
    chk("R3", int'(src0_phys_o), model(63, exp_off));

    // R7: mid-run reset restores identity
    @(negedge clk_i);
    rst_ni = 1'b0; exp_off = 0; #1;
    chk("R7", int'(src0_phys_o), 63);
    @(negedge clk_i); rst_ni = 1'b1;
    sweep();

    summary();
    $finish;
  end
endmodule